// File: doc/BRIEF.md
# Byte-Streamed Packet Mailbox

This block lets a host processor exchange whole packets with a network-side byte stream, one byte per register access. A received packet lands in an internal buffer. A length register then shows how many bytes remain, and every read of the receive data port pops the next byte. To transmit, the host programs a length and pushes exactly that many bytes through the transmit data port. The block then streams the packet out with start and end markers. It clears the visible transmit length as soon as the last byte has been taken, which can be before the stream has finished sending.

A single level interrupt combines three sources. Two are write-one-to-clear flags, one for transmit completion and one for receive data waiting. The third is a test interrupt that software raises by writing bit 31. Reading the interrupt register clears the visible bit 31, and only a write of zero retires the pending test interrupt. While the receive flag is set, or unread receive bytes remain, the receive stream is held off with backpressure. The identification word, the interrupt line index and the buffer size are parameters.

Top module: `pkt_mailbox`

## Requirements
- R1: The 64-bit identification word reads at word offsets 0x00 (low half) and 0x04 (high half). Its eight ASCII characters come from the ID_TEXT parameter, and the first character sits in bits 7:0 of offset 0x00.
- R2: When a packet ends (rx_eop accepted), the receive count at 0x0C equals its byte length. Each read of 0x1C returns the next byte in bits 7:0, with bits 31:8 zero, and lowers the count by one. A read of 0x1C when the count is 0 returns 0 and changes nothing.
- R3: Bit 1 of the interrupt register at 0x14 is set when a packet ends, and writing 1 to bit 1 clears it. rx_ready is low while bit 1 is set or the receive count is nonzero.
- R4: A write to 0x10 loads the transmit length. Each write to 0x20 then stores bits 7:0 as the next byte. After the last byte, 0x10 reads 0.
- R5: The stored packet goes out on tx_data in write order. tx_sop is set only on the first byte and tx_eop only on the last, and data and markers hold while tx_ready is low.
- R6: Bit 0 of the interrupt register is set when the last transmit byte is accepted downstream, and writing 1 to bit 0 clears it.
- R7: Writing 1 to bit 31 of 0x14 raises the test interrupt and makes bit 31 read 1. A read of 0x14 clears bit 31 but leaves the interrupt pending. A write of 0 to 0x14 clears the pending test interrupt.
- R8: The irq output is high exactly when bit 0, bit 1 or the pending test interrupt is set.
- R9: Bit 0 of 0x08 reads 1 while a receive packet is being filled or a transmit packet is being streamed, and 0 otherwise.
- R10: Offset 0x18 reads the IRQ_INDEX parameter. Writes to the read-only offsets (0x00 to 0x0C, 0x18, 0x1C) have no effect. Reads of unmapped or misaligned offsets return 0.
- R11: Packets hold up to MAX_BYTES bytes. A transmit length above MAX_BYTES is ignored. Receive bytes beyond MAX_BYTES are discarded, and the count stops at MAX_BYTES.
- R12: Receive bytes that arrive while idle without rx_sop are discarded and do not load the receive count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sop | input | 1 | First byte of a receive packet |
| rx_eop | input | 1 | Last byte of a receive packet |
| rx_ready | output | 1 | Block accepts a receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of a transmit packet |
| tx_eop | output | 1 | Last byte of a transmit packet |
| tx_ready | input | 1 | Downstream accepts the transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the receive admission rule. A design that reopened rx_ready when the flag was cleared, with bytes still unread, would overwrite the held packet. A design that accepted bytes with no start marker would load a bogus count. It overfills the receive buffer and programs an oversized transmit length. A count that wrapped, or a length that was accepted, would show at 0x0C and 0x10. It separates the visible test bit from the pending test interrupt: a design that dropped irq on the clearing read, or kept bit 31 set after it, reads back wrongly. It stalls the transmit stream at random to catch markers or data that change while tx_ready is low.

// File: rtl/pkt_mbox_pkg.sv
`timescale 1ns/1ps
package pkt_mbox_pkg;
   // word indices (byte offset / 4) of the register map
   localparam int unsigned REG_ID_LO = 0;
   localparam int unsigned REG_ID_HI = 1;
   localparam int unsigned REG_BUSY  = 2;
   localparam int unsigned REG_RXCNT = 3;
   localparam int unsigned REG_TXCNT = 4;
   localparam int unsigned REG_IRQ   = 5;
   localparam int unsigned REG_INFO  = 6;
   localparam int unsigned REG_RXDAT = 7;
   localparam int unsigned REG_TXDAT = 8;

   localparam int unsigned IRQ_TX_BIT   = 0;
   localparam int unsigned IRQ_RX_BIT   = 1;
   localparam int unsigned IRQ_TEST_BIT = 31;

   typedef enum logic {RX_IDLE, RX_FILL} rx_state_e;
   typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_e;
endpackage

// File: rtl/pkt_mbox_rx.sv
`timescale 1ns/1ps
module pkt_mbox_rx
   import pkt_mbox_pkg::*;
#(
   parameter int MAX_BYTES = 2048,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1),
   parameter int AW        = $clog2(MAX_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_valid,
   input  logic [7:0]       s_data,
   input  logic             s_sop,
   input  logic             s_eop,
   output logic             s_ready,
   input  logic             hold,
   input  logic             pop,
   output logic [7:0]       pop_byte,
   output logic [CNT_W-1:0] count,
   output logic             filling,
   output logic             done
);
   localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_BYTES);

   rx_state_e        state;
   logic [CNT_W-1:0] wptr;
   logic [AW-1:0]    rptr;
   logic [7:0]       mem [MAX_BYTES];
   logic             take, room, start, wr_mem;
   logic [AW-1:0]    wr_idx;

   assign s_ready  = (state == RX_FILL) || (!hold && count == '0);
   assign take     = s_valid && s_ready;
   assign start    = take && (state == RX_IDLE) && s_sop;
   assign room     = wptr < MAXC;
   assign done     = take && s_eop && ((state == RX_FILL) || s_sop);
   assign filling  = (state == RX_FILL);
   assign wr_mem   = start || (take && state == RX_FILL && room);
   assign wr_idx   = start ? '0 : wptr[AW-1:0];
   assign pop_byte = (count != '0) ? mem[rptr] : 8'h00;

   always_ff @(posedge clk) begin
      if (wr_mem) mem[wr_idx] <= s_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (start) begin
            wptr <= CNT_W'(1);
            if (s_eop) begin
               count <= CNT_W'(1);
               rptr  <= '0;
            end else begin
               state <= RX_FILL;
            end
         end else if (take && state == RX_FILL) begin
            if (room) wptr <= wptr + 1'b1;
            if (s_eop) begin
               count <= room ? wptr + 1'b1 : wptr;
               rptr  <= '0;
               state <= RX_IDLE;
            end
         end else if (pop && count != '0) begin
            count <= count - 1'b1;
            rptr  <= rptr + 1'b1;
         end
      end
   end

   p_rx_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count != '0 && state == RX_IDLE && !take) |=> count == $past(count) - 1'b1);
   p_rx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> count != '0);
   p_rx_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      count <= MAXC);
endmodule

// File: rtl/pkt_mbox_tx.sv
`timescale 1ns/1ps
module pkt_mbox_tx
   import pkt_mbox_pkg::*;
#(
   parameter int MAX_BYTES = 2048,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1),
   parameter int AW        = $clog2(MAX_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_wr,
   input  logic [31:0]      len_val,
   input  logic             byte_wr,
   input  logic [7:0]       byte_val,
   output logic [CNT_W-1:0] count,
   output logic             m_valid,
   output logic [7:0]       m_data,
   output logic             m_sop,
   output logic             m_eop,
   input  logic             m_ready,
   output logic             sending,
   output logic             done
);
   tx_state_e        state;
   logic [CNT_W-1:0] len;
   logic [AW-1:0]    wptr;
   logic [AW-1:0]    rdptr;
   logic [7:0]       mem [MAX_BYTES];
   logic             len_ok, last_wr;

   assign len_ok  = (len_val <= 32'(MAX_BYTES));
   assign last_wr = (CNT_W'(wptr) == len - 1'b1);
   assign sending = (state == TX_SEND);
   assign count   = (state == TX_LOAD) ? len : '0;
   assign m_valid = sending;
   assign m_data  = mem[rdptr];
   assign m_sop   = sending && (rdptr == '0);
   assign m_eop   = sending && (CNT_W'(rdptr) == len - 1'b1);
   assign done    = m_valid && m_ready && m_eop;

   always_ff @(posedge clk) begin
      if (byte_wr && state == TX_LOAD) mem[wptr] <= byte_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         len   <= '0;
         wptr  <= '0;
         rdptr <= '0;
      end else begin
         unique case (state)
            TX_IDLE, TX_LOAD: begin
               if (len_wr && len_ok) begin
                  len   <= len_val[CNT_W-1:0];
                  wptr  <= '0;
                  state <= (len_val == 32'd0) ? TX_IDLE : TX_LOAD;
               end else if (byte_wr && state == TX_LOAD) begin
                  wptr <= wptr + 1'b1;
                  if (last_wr) begin
                     state <= TX_SEND;
                     rdptr <= '0;
                  end
               end
            end
            TX_SEND: begin
               if (m_ready) begin
                  if (m_eop) state <= TX_IDLE;
                  else       rdptr <= rdptr + 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop));
   p_tx_len_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != TX_IDLE) |-> (len != '0 && len <= CNT_W'(MAX_BYTES)));
   p_tx_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sending) |-> count == '0);
endmodule

// File: rtl/pkt_mbox_irq.sv
`timescale 1ns/1ps
module pkt_mbox_irq
   import pkt_mbox_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_set,
   input  logic        rx_set,
   input  logic        wr,
   input  logic [31:0] wdata,
   input  logic        rd,
   output logic        tx_flag,
   output logic        rx_flag,
   output logic        test_vis,
   output logic        irq
);
   logic test_pend;
   logic wr_zero, wr_test;

   assign wr_zero = wr && (wdata == 32'd0);
   assign wr_test = wr && wdata[IRQ_TEST_BIT];
   assign irq     = tx_flag || rx_flag || test_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_flag   <= 1'b0;
         rx_flag   <= 1'b0;
         test_vis  <= 1'b0;
         test_pend <= 1'b0;
      end else begin
         if (tx_set)                          tx_flag <= 1'b1;
         else if (wr && wdata[IRQ_TX_BIT])    tx_flag <= 1'b0;
         if (rx_set)                          rx_flag <= 1'b1;
         else if (wr && wdata[IRQ_RX_BIT])    rx_flag <= 1'b0;
         if (wr_test)                         test_vis <= 1'b1;
         else if (rd || wr_zero)              test_vis <= 1'b0;
         if (wr_test)                         test_pend <= 1'b1;
         else if (wr_zero)                    test_pend <= 1'b0;
      end
   end

   p_test_rdclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr) |=> !test_vis);
   p_test_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (test_pend && !wr) |=> irq);
   p_rx_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[IRQ_RX_BIT] && !rx_set) |=> !rx_flag);
endmodule

// File: rtl/pkt_mailbox.sv
`timescale 1ns/1ps
module pkt_mailbox
   import pkt_mbox_pkg::*;
#(
   parameter int          MAX_BYTES = 2048,
   parameter int          ADDR_W    = 6,
   parameter logic [63:0] ID_TEXT   = "PKTMBOX0",
   parameter int          IRQ_INDEX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_sop,
   input  logic              rx_eop,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_sop,
   output logic              tx_eop,
   input  logic              tx_ready,
   output logic              irq
);
   localparam int CNT_W = $clog2(MAX_BYTES + 1);
   localparam int AW    = $clog2(MAX_BYTES);

   if (MAX_BYTES < 2 || MAX_BYTES > 65536) begin : g_bad_max
      $error("MAX_BYTES must lie in 2..65536");
   end
   if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 6..16");
   end

   // identification word, first character in the lowest byte
   logic [63:0] id_le;
   for (genvar i = 0; i < 8; i++) begin : g_id
      assign id_le[8*i +: 8] = ID_TEXT[8*(7-i) +: 8];
   end

   int unsigned      word_idx;
   logic             aligned;
   logic             hit_rxdat, hit_txdat, hit_txcnt, hit_irq;
   logic [7:0]       pop_byte;
   logic [CNT_W-1:0] rx_cnt, tx_cnt;
   logic             rx_fill, rx_done, tx_send, tx_done;
   logic             tx_flag, rx_flag, test_vis;
   logic             busy;
   logic [31:0]      rd_mux;

   assign word_idx  = 32'(bus_addr[ADDR_W-1:2]);
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign hit_rxdat = aligned && word_idx == REG_RXDAT;
   assign hit_txdat = aligned && word_idx == REG_TXDAT;
   assign hit_txcnt = aligned && word_idx == REG_TXCNT;
   assign hit_irq   = aligned && word_idx == REG_IRQ;
   assign busy      = rx_fill || tx_send;

   pkt_mbox_rx #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .AW(AW)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .s_valid(rx_valid), .s_data(rx_data), .s_sop(rx_sop), .s_eop(rx_eop),
      .s_ready(rx_ready), .hold(rx_flag),
      .pop(bus_rd && hit_rxdat), .pop_byte(pop_byte), .count(rx_cnt),
      .filling(rx_fill), .done(rx_done)
   );

   pkt_mbox_tx #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .AW(AW)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .len_wr(bus_wr && hit_txcnt), .len_val(bus_wdata),
      .byte_wr(bus_wr && hit_txdat), .byte_val(bus_wdata[7:0]),
      .count(tx_cnt),
      .m_valid(tx_valid), .m_data(tx_data), .m_sop(tx_sop), .m_eop(tx_eop),
      .m_ready(tx_ready), .sending(tx_send), .done(tx_done)
   );

   pkt_mbox_irq u_irq (
      .clk(clk), .rst_n(rst_n),
      .tx_set(tx_done), .rx_set(rx_done),
      .wr(bus_wr && hit_irq), .wdata(bus_wdata), .rd(bus_rd && hit_irq),
      .tx_flag(tx_flag), .rx_flag(rx_flag), .test_vis(test_vis), .irq(irq)
   );

   always_comb begin
      rd_mux = 32'd0;
      if (aligned) begin
         unique case (word_idx)
            REG_ID_LO: rd_mux = id_le[31:0];
            REG_ID_HI: rd_mux = id_le[63:32];
            REG_BUSY:  rd_mux = {31'd0, busy};
            REG_RXCNT: rd_mux = 32'(rx_cnt);
            REG_TXCNT: rd_mux = 32'(tx_cnt);
            REG_IRQ:   rd_mux = {test_vis, 29'd0, rx_flag, tx_flag};
            REG_INFO:  rd_mux = 32'(IRQ_INDEX);
            REG_RXDAT: rd_mux = {24'd0, pop_byte};
            default:   rd_mux = 32'd0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= 32'd0;
      else        bus_rdata <= bus_rd ? rd_mux : 32'd0;
   end

   p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == 32'd0);
   p_busy_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> busy);
   p_rx_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag && !rx_fill) |-> !rx_ready);
   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag || rx_flag) |-> irq);
endmodule

// File: tb/pkt_mailbox_bench.sv
`timescale 1ns/1ps
module pkt_mailbox_bench;
   localparam int MAXB = 64;
   localparam int IRQI = 3;
   localparam logic [5:0] A_IDLO = 6'h00, A_IDHI = 6'h04, A_BUSY = 6'h08,
      A_RXC = 6'h0C, A_TXC = 6'h10, A_IRQ = 6'h14, A_INFO = 6'h18,
      A_RXD = 6'h1C, A_TXD = 6'h20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_ready;
   logic [7:0] rx_data = '0, tx_data;
   logic tx_valid, tx_sop, tx_eop;
   logic tx_ready = 1'b0, irq;

   int n_vec = 0, n_bad = 0;
   logic [7:0] pkt [0:127];
   logic [7:0] cap_d [0:127];
   logic cap_s [0:127];
   logic cap_e [0:127];
   int cap_n = 0;
   bit sink_en = 1'b0;

   pkt_mailbox #(.MAX_BYTES(MAXB), .ADDR_W(6), .IRQ_INDEX(IRQI)) u_pkt_mailbox (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_ready(tx_ready), .irq(irq)
   );

   always #2.5 clk = ~clk;

   function automatic logic [31:0] id_lo();
      return {"M", "T", "K", "P"};
   endfunction
   function automatic logic [31:0] id_hi();
      return {"0", "X", "O", "B"};
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic send_rx(int first, int len, bit sop_on, bit eop_on);
      @(negedge clk);
      for (int i = first; i < first + len; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         rx_valid = 1'b1; rx_data = pkt[i];
         rx_sop = sop_on && (i == first);
         rx_eop = eop_on && (i == first + len - 1);
         while (!rx_ready) @(negedge clk);
         @(negedge clk);
         rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
      end
   endtask

   // downstream sink with random stalls
   always @(negedge clk) begin
      tx_ready = sink_en ? (($urandom % 4) != 0) : 1'b0;
      if (tx_valid && tx_ready) begin
         cap_d[cap_n] = tx_data; cap_s[cap_n] = tx_sop; cap_e[cap_n] = tx_eop;
         cap_n++;
      end
   end

   task automatic rx_packet(int len, int expc);
      logic [31:0] d;
      for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
      send_rx(0, len, 1'b1, 1'b1);
      chk("R3 rx_ready low after packet", {31'd0, rx_ready}, 32'd0);
      chk("R8 irq from rx flag", {31'd0, irq}, 32'd1);
      bus_read(A_IRQ, d);  chk("R3 irq reg rx bit", d, 32'h2);
      bus_read(A_RXC, d);  chk("R2 rx count", d, 32'(expc));
      bus_write(A_IRQ, 32'h2);
      chk("R3 rx_ready still low with unread bytes", {31'd0, rx_ready}, 32'd0);
      chk("R8 irq cleared", {31'd0, irq}, 32'd0);
      for (int i = 0; i < expc; i++) begin
         bus_read(A_RXD, d); chk("R2 rx byte", d, {24'd0, pkt[i]});
      end
      bus_read(A_RXC, d);  chk("R2 rx count drained", d, 32'd0);
      bus_read(A_RXD, d);  chk("R2 empty pop", d, 32'd0);
      chk("R3 rx_ready back", {31'd0, rx_ready}, 32'd1);
   endtask

   task automatic tx_packet(int len);
      logic [31:0] d;
      for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
      cap_n = 0;
      bus_write(A_TXC, 32'(len));
      bus_read(A_TXC, d); chk("R4 tx count loaded", d, 32'(len));
      for (int i = 0; i < len; i++) bus_write(A_TXD, {24'($urandom), pkt[i]});
      bus_read(A_TXC, d); chk("R4 tx count cleared when taken", d, 32'd0);
      bus_read(A_BUSY, d); chk("R9 busy while streaming", d, 32'd1);
      chk("R5 first byte sop", {30'd0, tx_valid, tx_sop}, 32'd3);
      sink_en = 1'b1;
      for (int w = 0; w < 1000 && !irq; w++) @(negedge clk);
      sink_en = 1'b0;
      chk("R5 byte count out", 32'(cap_n), 32'(len));
      for (int i = 0; i < len; i++) begin
         chk("R5 tx byte", {24'd0, cap_d[i]}, {24'd0, pkt[i]});
         chk("R5 tx markers", {30'd0, cap_s[i], cap_e[i]},
             {30'd0, i == 0, i == len - 1});
      end
      bus_read(A_BUSY, d); chk("R9 busy clear", d, 32'd0);
      bus_read(A_IRQ, d); chk("R6 tx done bit", d, 32'h1);
      bus_write(A_IRQ, 32'h1);
      chk("R6 w1c tx done drops irq", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R8 irq at reset", {31'd0, irq}, 32'd0);
      chk("R3 rx_ready at reset", {31'd0, rx_ready}, 32'd1);
      chk("R5 tx idle at reset", {31'd0, tx_valid}, 32'd0);
      bus_read(A_BUSY, d); chk("R9 busy at reset", d, 32'd0);
      bus_read(A_RXC, d);  chk("R2 rx count at reset", d, 32'd0);
      bus_read(A_TXC, d);  chk("R4 tx count at reset", d, 32'd0);
      bus_read(A_IRQ, d);  chk("R7 irq reg at reset", d, 32'd0);
      // identification and read-only space
      bus_read(A_IDLO, d); chk("R1 id low", d, id_lo());
      bus_read(A_IDHI, d); chk("R1 id high", d, id_hi());
      bus_read(A_INFO, d); chk("R10 info", d, 32'(IRQI));
      bus_write(A_IDLO, 32'hFFFF_FFFF);
      bus_write(A_INFO, 32'h5A5A_5A5A);
      bus_write(A_RXC, 32'h0000_0010);
      bus_read(A_IDLO, d); chk("R10 id after write", d, id_lo());
      bus_read(A_INFO, d); chk("R10 info after write", d, 32'(IRQI));
      bus_read(A_RXC, d);  chk("R10 rx count after write", d, 32'd0);
      bus_read(6'h24, d);  chk("R10 unmapped 0x24", d, 32'd0);
      bus_read(6'h3C, d);  chk("R10 unmapped 0x3C", d, 32'd0);
      bus_read(6'h01, d);  chk("R10 misaligned", d, 32'd0);
      // orphan byte without start marker
      pkt[0] = 8'hA5;
      send_rx(0, 1, 1'b0, 1'b1);
      bus_read(A_RXC, d);  chk("R12 orphan count", d, 32'd0);
      chk("R12 orphan no irq", {31'd0, irq}, 32'd0);
      // directed: single byte, then random lengths
      rx_packet(1, 1);
      for (int k = 0; k < 4; k++) begin
         int len = 1 + ($urandom % 40);
         rx_packet(len, len);
      end
      // busy during fill
      pkt[0] = 8'h11; pkt[1] = 8'h22;
      send_rx(0, 1, 1'b1, 1'b0);
      bus_read(A_BUSY, d); chk("R9 busy while filling", d, 32'd1);
      send_rx(1, 1, 1'b0, 1'b1);
      bus_read(A_RXC, d);  chk("R2 split packet count", d, 32'd2);
      bus_write(A_IRQ, 32'h2);
      bus_read(A_RXD, d);  chk("R2 split byte0", d, 32'h11);
      bus_read(A_RXD, d);  chk("R2 split byte1", d, 32'h22);
      // receive overflow capped at MAXB
      rx_packet(MAXB + 6, MAXB);
      // transmit: directed and random
      tx_packet(1);
      for (int k = 0; k < 3; k++) tx_packet(2 + ($urandom % 40));
      tx_packet(MAXB);
      bus_write(A_TXC, 32'(MAXB + 1));
      bus_read(A_TXC, d);  chk("R11 oversize length ignored", d, 32'd0);
      bus_write(A_TXD, 32'h77);
      chk("R11 no stream after ignored length", {31'd0, tx_valid}, 32'd0);
      // test interrupt
      bus_write(A_IRQ, 32'h8000_0000);
      chk("R7 test raises irq", {31'd0, irq}, 32'd1);
      bus_read(A_IRQ, d);  chk("R7 bit31 visible", d, 32'h8000_0000);
      bus_read(A_IRQ, d);  chk("R7 bit31 cleared by read", d, 32'd0);
      chk("R8 test still pending", {31'd0, irq}, 32'd1);
      bus_write(A_IRQ, 32'h3);
      chk("R7 w1c does not retire test", {31'd0, irq}, 32'd1);
      bus_write(A_IRQ, 32'd0);
      chk("R7 write zero retires test", {31'd0, irq}, 32'd0);
      // both flags together
      tx_packet(5);
      pkt[0] = 8'h5C;
      send_rx(0, 1, 1'b1, 1'b1);
      bus_write(A_TXC, 32'd1);
      bus_write(A_TXD, 32'h9E);
      sink_en = 1'b1;
      for (int w = 0; w < 200 && tx_valid; w++) @(negedge clk);
      sink_en = 1'b0;
      bus_read(A_IRQ, d);  chk("R6 both flags", d, 32'h3);
      bus_write(A_IRQ, 32'h1);
      chk("R8 rx flag keeps irq", {31'd0, irq}, 32'd1);
      bus_write(A_IRQ, 32'h2);
      chk("R8 all clear", {31'd0, irq}, 32'd0);
      bus_read(A_RXD, d);  chk("R2 last rx byte", d, 32'h5C);
      summary();
      $finish;
   end
endmodule